// File: doc/BRIEF.md
# USB Function Address Register with Deferred Commit

This block holds the function address of a USB device controller. Firmware sees one 8-bit register through a simple CPU port. When the host sends a SET_ADDRESS request, firmware writes the new address into that register. The value written goes into a staged copy, and CPU reads return that staged copy. The token matcher works from a second, live copy.

The live copy takes the staged value only when the control transfer's status stage ends with an acknowledged handshake from the device. The packet engine signals that moment with a one-cycle strobe. If the status stage fails, no strobe arrives. The live address then stays as it was, and the staged value waits for the next successful status stage.

A USB bus reset returns the device to the default address zero. The match output tells the token decoder whether an incoming token is addressed to this function.

Top module: `usb_func_addr`

## Requirements
- R1: After the synchronous reset `rst`, the CPU read value, the live address and the match state all correspond to address zero.
- R2: A CPU write stores bits 6..0 of the write data as the staged address. From the next cycle, the read value is 0 in bit 7 and the staged address in bits 6..0, whatever was written to bit 7.
- R3: A CPU write without a commit strobe leaves the live address and the match result unchanged.
- R4: A commit strobe (`status_ack_i` high for one cycle) copies the staged address into the live address at that clock edge.
- R5: While no commit strobe arrives, the live address holds for any number of cycles, and the staged value stays pending until a later strobe commits it.
- R6: When a CPU write and a commit strobe occur in the same cycle, the live address takes the previously staged value and the new write becomes the staged value.
- R7: A USB bus reset (`bus_reset_i` high) clears both the staged and the live address to zero at the same edge. It takes priority over a simultaneous write or commit.
- R8: `addr_hit_o` is high in the same cycle exactly when `tok_valid_i` is high and `tok_addr_i` equals the live address.
- R9: `live_addr_o` always shows the live address that the matcher uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | USB bus reset seen on the wire; clears both addresses |
| cpu_wr_i | input | 1 | CPU write enable for the address register |
| cpu_wdata_i | input | 8 | CPU write data; bits 6..0 are the address |
| cpu_rdata_o | output | 8 | Read value: bit 7 zero, bits 6..0 staged address |
| status_ack_i | input | 1 | One-cycle strobe: status stage ended with ACK |
| tok_valid_i | input | 1 | Incoming token address is valid |
| tok_addr_i | input | 7 | Address field of the incoming token |
| addr_hit_o | output | 1 | Token is addressed to this function |
| live_addr_o | output | 7 | Address currently in effect |

## Verification
The bench first writes a new address and then holds back the commit strobe for many cycles. Tokens carrying the old address and tokens carrying the new one separate a design that commits early from one that defers correctly. It then drives a write and a strobe in the same cycle, and a bus reset together with both. These patterns show whether the live copy takes the old staged value and whether reset has priority. A closing stretch of pseudo-random writes, strobes, resets and tokens is compared cycle by cycle against a behavioural model. It exposes any mix-up of the staged and live copies that the directed cases miss.

// File: rtl/usb_func_addr_pkg.sv
package usb_func_addr_pkg;

    localparam int unsigned FA_ADDR_W = 7;
    localparam int unsigned FA_REG_W  = 8;

    typedef logic [FA_ADDR_W-1:0] fa_addr_t;

    // both copies of the function address
    typedef struct packed {
        fa_addr_t staged;
        fa_addr_t live;
    } fa_state_t;

    // one cycle of requested update, decoded from the CPU port
    typedef struct packed {
        logic     stage_we;
        fa_addr_t stage_val;
    } fa_stage_req_t;

    function automatic fa_addr_t fa_take_addr(input logic [FA_REG_W-1:0] word);
        return word[FA_ADDR_W-1:0];
    endfunction

    function automatic logic [FA_REG_W-1:0] fa_read_word(input fa_addr_t a);
        return {{(FA_REG_W-FA_ADDR_W){1'b0}}, a};
    endfunction

endpackage

// File: rtl/ufa_cpu_port.sv
module ufa_cpu_port
    import usb_func_addr_pkg::*;
(
    input  logic                cpu_wr,
    input  logic [FA_REG_W-1:0] cpu_wdata,
    input  fa_addr_t            staged,
    output fa_stage_req_t       req,
    output logic [FA_REG_W-1:0] cpu_rdata
);
    // reserved upper bits are discarded on write
    logic unused_rsvd;
    assign unused_rsvd = ^cpu_wdata[FA_REG_W-1:FA_ADDR_W];

    always_comb begin
        req.stage_we  = cpu_wr;
        req.stage_val = fa_take_addr(cpu_wdata);
    end

    assign cpu_rdata = fa_read_word(staged);
endmodule

// File: rtl/ufa_commit.sv
module ufa_commit
    import usb_func_addr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_reset,
    input  logic          commit,
    input  fa_stage_req_t req,
    output fa_state_t     st
);
    fa_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (bus_reset) begin
            st_d.staged = '0;
            st_d.live   = '0;
        end else begin
            if (commit)       st_d.live   = st_q.staged;
            if (req.stage_we) st_d.staged = req.stage_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st = st_q;

    assert_write_stages_R2: assert property (@(posedge clk) disable iff (rst)
        (req.stage_we && !bus_reset) |=> (st_q.staged == $past(req.stage_val)));

    assert_live_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!commit && !bus_reset) |=> $stable(st_q.live));

    assert_commit_copies_R4: assert property (@(posedge clk) disable iff (rst)
        (commit && !bus_reset) |=> (st_q.live == $past(st_q.staged)));

    assert_bus_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (st_q.live == '0 && st_q.staged == '0));
endmodule

// File: rtl/ufa_match.sv
module ufa_match
    import usb_func_addr_pkg::*;
(
    input  logic     tok_valid,
    input  fa_addr_t tok_addr,
    input  fa_addr_t live,
    output logic     hit
);
    logic [FA_ADDR_W-1:0] bit_eq;

    for (genvar i = 0; i < FA_ADDR_W; i++) begin : g_cmp
        assign bit_eq[i] = ~(tok_addr[i] ^ live[i]);
    end

    assign hit = tok_valid & (&bit_eq);
endmodule

// File: rtl/usb_func_addr.sv
module usb_func_addr
    import usb_func_addr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_reset_i,
    input  logic                cpu_wr_i,
    input  logic [FA_REG_W-1:0] cpu_wdata_i,
    output logic [FA_REG_W-1:0] cpu_rdata_o,
    input  logic                status_ack_i,
    input  logic                tok_valid_i,
    input  logic [FA_ADDR_W-1:0] tok_addr_i,
    output logic                addr_hit_o,
    output logic [FA_ADDR_W-1:0] live_addr_o
);
    fa_stage_req_t req;
    fa_state_t     st;

    ufa_cpu_port u_port (
        .cpu_wr    (cpu_wr_i),
        .cpu_wdata (cpu_wdata_i),
        .staged    (st.staged),
        .req       (req),
        .cpu_rdata (cpu_rdata_o)
    );

    ufa_commit u_commit (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset_i),
        .commit    (status_ack_i),
        .req       (req),
        .st        (st)
    );

    ufa_match u_match (
        .tok_valid (tok_valid_i),
        .tok_addr  (tok_addr_i),
        .live      (st.live),
        .hit       (addr_hit_o)
    );

    assign live_addr_o = st.live;

    assert_hit_needs_token_R8: assert property (@(posedge clk) disable iff (rst)
        addr_hit_o |-> (tok_valid_i && tok_addr_i == live_addr_o));
endmodule

// File: tb/tb_usb_func_addr.sv
`timescale 1ns/1ps
module tb_usb_func_addr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_reset_i = 1'b0;
    logic       cpu_wr_i = 1'b0;
    logic [7:0] cpu_wdata_i = '0;
    logic [7:0] cpu_rdata_o;
    logic       status_ack_i = 1'b0;
    logic       tok_valid_i = 1'b0;
    logic [6:0] tok_addr_i = '0;
    logic       addr_hit_o;
    logic [6:0] live_addr_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int m_staged = 0;
    int m_live = 0;

    always #2.5 clk = ~clk;

    usb_func_addr dut (
        .clk(clk), .rst(rst), .bus_reset_i(bus_reset_i),
        .cpu_wr_i(cpu_wr_i), .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
        .status_ack_i(status_ack_i), .tok_valid_i(tok_valid_i), .tok_addr_i(tok_addr_i),
        .addr_hit_o(addr_hit_o), .live_addr_o(live_addr_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive, update model at the edge, compare after it
    task automatic step(input bit wr, input int wd, input bit ack, input bit br,
                        input bit tv, input int ta, input string tag);
        @(negedge clk);
        cpu_wr_i = wr; cpu_wdata_i = wd[7:0]; status_ack_i = ack;
        bus_reset_i = br; tok_valid_i = tv; tok_addr_i = ta[6:0];
        @(posedge clk);
        if (br) begin
            m_staged = 0; m_live = 0;
        end else begin
            if (ack) m_live = m_staged;
            if (wr) m_staged = wd & 'h7f;
        end
        #1;
        check({tag, " rdata R2"}, int'(cpu_rdata_o), m_staged);
        check({tag, " live R9"}, int'(live_addr_o), m_live);
        check({tag, " hit R8"}, int'(addr_hit_o), int'(tv && ((ta & 'h7f) == m_live)));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check("R1 reset rdata", int'(cpu_rdata_o), 0);
        check("R1 reset live", int'(live_addr_o), 0);
        step(0, 0, 0, 0, 1, 0, "R1 hit at zero");
        // write with bit 7 set: staged only (R2, R3)
        step(1, 'h85, 0, 0, 1, 5, "R3 write no commit, token new");
        step(0, 0, 0, 0, 1, 0, "R3 token old address");
        // long wait, no strobe (R5)
        for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, 5, "R5 pending");
        check("R5 live still zero", int'(live_addr_o), 0);
        step(0, 0, 1, 0, 1, 5, "R4 commit");
        check("R4 live after commit", int'(live_addr_o), 5);
        // simultaneous write and commit (R6)
        step(1, 'h11, 0, 0, 0, 0, "R6 prep");
        step(1, 'h22, 1, 0, 1, 'h11, "R6 write+commit");
        check("R6 live old staged", int'(live_addr_o), 'h11);
        check("R6 staged new", int'(cpu_rdata_o), 'h22);
        // bus reset wins over write and commit (R7)
        step(1, 'h33, 1, 1, 1, 0, "R7 bus reset");
        check("R7 live zero", int'(live_addr_o), 0);
        check("R7 staged zero", int'(cpu_rdata_o), 0);
        // top address boundary
        step(1, 'hff, 0, 0, 0, 0, "R2 max");
        check("R2 bit7 reads zero", int'(cpu_rdata_o), 'h7f);
        step(0, 0, 1, 0, 1, 'h7f, "R4 max commit");
        step(0, 0, 0, 0, 0, 'h7f, "R8 invalid token");
        lfsr = 'hace1;
        for (int i = 0; i < 400; i++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hffff;
            step(lfsr[0], lfsr[10:3], lfsr[1] & lfsr[2], (lfsr[15:11] == 0),
                 lfsr[11], lfsr[1] ? m_live : lfsr[14:8], "R5 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule